// File: doc/BRIEF.md
# Page-Translated DMA Channel Engine

This block is a single DMA channel that moves bytes between a device byte stream and system memory. Software programs a logical start address, a byte count, a translation table base and a direction bit through a small register port, then the device side pulses a start request giving its own byte budget and the direction it expects. Each 4 KB page of the logical address range is remapped through a 32-bit entry that the engine reads from the translation table before it moves any data in that page.

Data moves one byte per memory beat. Before each run the engine looks at the physical address and the bytes still owed. Long runs of 256 bytes go out on 256-byte aligned addresses and medium runs of 16 bytes on 16-byte aligned ones. Anything else moves as a single byte. Every data beat carries the length of the run it belongs to, so a downstream fabric can merge the beats into bursts. Runs never span a page, and a new table entry is fetched whenever the logical address enters a new page.

Top module: `pdma_engine`

## Requirements
- R1: The table entry for a page is fetched as one word read (mem_word=1) from table_base + (logical_address >> 12) * 8. With BIG_ENDIAN=1 the byte at the lowest address (mem_rdata[7:0]) becomes the most significant byte of the entry.
- R2: The physical address of each data beat is the entry with its low 12 bits cleared, plus the low 12 bits of the current logical address. Data bytes travel on mem_wdata and mem_rdata[7:0].
- R3: With avail = bytes still owed, a run is 256 bytes when physical address bits [7:0] are zero and avail >= 256. It is 16 bytes when bits [3:0] are zero and avail >= 16. Otherwise it is 1 byte. mem_run shows the run length on every data beat.
- R4: A new table fetch is issued at the start of a transfer and each time the logical address crosses into a new 4 KB page. No run spans a page.
- R5: An accepted transfer moves exactly min(xfer_len, count register) bytes, in logical address order. The logical address rises by one for each byte moved, and the byte stream order is kept in both directions.
- R6: Enable register bit 1 set means memory to device (xfer_to_mem=0 is accepted). Bit 1 clear means device to memory (xfer_to_mem=1). If xfer_to_mem does not match bit 1, or run bit 0 is clear, the start is rejected: a done pulse, xfer_moved=0, no memory access, and the count register is unchanged.
- R7: After a transfer completes the count register reads 0 and xfer_moved holds the number of bytes moved. A start with zero length or zero count completes at once with zero bytes moved.
- R8: Register offset 0 (configuration) always reads 0x104, and writes to it are ignored.
- R9: Offsets 1 (mode), 2 (enable), 3 (count), 4 (logical start), 5 (table base) and 6 (table limit) read back what was written. A write to offset 7 (table invalidate) is ignored, and that offset reads 0.
- R10: xfer_busy is high from the cycle after an accepted start until the done pulse. xfer_done lasts one cycle and coincides with busy falling. No memory request is made while the engine is idle.
- R11: A memory request holds its address, direction and size until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational on reg_addr) |
| xfer_start | input | 1 | Start request from device side |
| xfer_to_mem | input | 1 | 1: device to memory, 0: memory to device |
| xfer_len | input | LW | Device byte budget |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle completion or reject pulse |
| xfer_moved | output | LW | Bytes moved by last transfer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_word | output | 1 | 1: 32-bit table read, 0: data byte |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Write byte |
| mem_run | output | RW | Run length of this data beat |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | AW | Read data |
| dev_in_valid | input | 1 | Device byte offered |
| dev_in_data | input | 8 | Device byte |
| dev_in_ready | output | 1 | Engine takes device byte |
| dev_out_valid | output | 1 | Byte offered to device |
| dev_out_data | output | 8 | Byte to device |
| dev_out_ready | input | 1 | Device takes byte |

## Verification
The bench targets transfers that start a few bytes before a page end. A design that skips the refetch there would put the bytes after the boundary at the old page's physical addresses. Transfers whose owed byte count falls just under 256 or 16 on an aligned address show whether the run sizing checks the bytes remaining; getting that wrong inflates mem_run and runs past the end. Transfers where the count register is shorter than the device budget, and the reverse, catch an engine that stops on only one limit. Rejected starts, zero-length starts and disabled runs confirm that no memory beat is issued and the count register keeps or clears its value correctly.

// File: rtl/pdma_engine.sv
module pdma_engine #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int PAGE_BITS = 12,
  parameter int LONG_RUN = 256,
  parameter int MED_RUN = 16,
  parameter int ENTRY_LG = 3,
  parameter bit BIG_ENDIAN = 1'b1,
  parameter int RW = $clog2(LONG_RUN) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          xfer_start,
  input  logic          xfer_to_mem,
  input  logic [LW-1:0] xfer_len,
  output logic          xfer_busy,
  output logic          xfer_done,
  output logic [LW-1:0] xfer_moved,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_word,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic [RW-1:0] mem_run,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  input  logic          dev_in_valid,
  input  logic [7:0]    dev_in_data,
  output logic          dev_in_ready,
  output logic          dev_out_valid,
  output logic [7:0]    dev_out_data,
  input  logic          dev_out_ready
);
  localparam int LONG_LG = $clog2(LONG_RUN);
  localparam int MED_LG  = $clog2(MED_RUN);
  localparam int EN_RUN  = 0;
  localparam int EN_WR   = 1;
  localparam logic [AW-1:0] CFG_ID = AW'(32'h104);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_PLAN, S_GET, S_MWR, S_MRD, S_PUT, S_END} state_t;
  state_t state;

  logic [AW-1:0] mode_r, enable_r, count_r, lstart_r, tbase_r, tlimit_r;
  logic [AW-1:0] cur, cnt_left, page;
  logic [LW-1:0] left, moved;
  logic [RW-1:0] run_len, run_left;
  logic [7:0]    byte_q;
  logic          to_mem_q;

  logic [AW-1:0] entry_sw, entry, paddr, taddr, avail, nxt;
  logic [RW-1:0] run_pick;
  logic          reject, empty, last_byte, run_end, page_cross, step;

  for (genvar g = 0; g < AW/8; g++) begin : g_swap
    assign entry_sw[8*g +: 8] = mem_rdata[AW-8-8*g +: 8];
  end
  assign entry = BIG_ENDIAN ? entry_sw : mem_rdata;

  assign paddr = {page[AW-1:PAGE_BITS], cur[PAGE_BITS-1:0]};
  assign taddr = tbase_r + ((cur >> PAGE_BITS) << ENTRY_LG);
  assign avail = (cnt_left < AW'(left)) ? cnt_left : AW'(left);
  assign nxt   = cur + AW'(1);

  always_comb begin
    if (paddr[LONG_LG-1:0] == '0 && avail >= AW'(LONG_RUN))
      run_pick = RW'(LONG_RUN);
    else if (paddr[MED_LG-1:0] == '0 && avail >= AW'(MED_RUN))
      run_pick = RW'(MED_RUN);
    else
      run_pick = RW'(1);
  end

  assign reject     = !enable_r[EN_RUN] || (xfer_to_mem == enable_r[EN_WR]);
  assign empty      = (xfer_len == '0) || (count_r == '0);
  assign last_byte  = (left == LW'(1)) || (cnt_left == AW'(1));
  assign run_end    = (run_left == RW'(1));
  assign page_cross = (nxt[PAGE_BITS-1:0] == '0);
  assign step = (state == S_MWR && mem_ack) || (state == S_PUT && dev_out_ready);

  assign mem_req       = (state == S_FETCH) || (state == S_MWR) || (state == S_MRD);
  assign mem_we        = (state == S_MWR);
  assign mem_word      = (state == S_FETCH);
  assign mem_addr      = (state == S_FETCH) ? taddr : paddr;
  assign mem_wdata     = byte_q;
  assign mem_run       = run_len;
  assign dev_in_ready  = (state == S_GET);
  assign dev_out_valid = (state == S_PUT);
  assign dev_out_data  = byte_q;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = CFG_ID;
      3'd1:    reg_rdata = mode_r;
      3'd2:    reg_rdata = enable_r;
      3'd3:    reg_rdata = count_r;
      3'd4:    reg_rdata = lstart_r;
      3'd5:    reg_rdata = tbase_r;
      3'd6:    reg_rdata = tlimit_r;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      mode_r <= '0; enable_r <= '0; count_r <= '0;
      lstart_r <= '0; tbase_r <= '0; tlimit_r <= '0;
      cur <= '0; cnt_left <= '0; page <= '0;
      left <= '0; moved <= '0; run_len <= '0; run_left <= '0;
      byte_q <= '0; to_mem_q <= 1'b0;
      xfer_busy <= 1'b0; xfer_done <= 1'b0; xfer_moved <= '0;
    end else begin
      xfer_done <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          3'd1: mode_r   <= reg_wdata;
          3'd2: enable_r <= reg_wdata;
          3'd3: count_r  <= reg_wdata;
          3'd4: lstart_r <= reg_wdata;
          3'd5: tbase_r  <= reg_wdata;
          3'd6: tlimit_r <= reg_wdata;
          default: ;
        endcase
      end
      case (state)
        S_IDLE: if (xfer_start) begin
          if (reject) begin
            xfer_done <= 1'b1;
            xfer_moved <= '0;
          end else if (empty) begin
            xfer_done <= 1'b1;
            xfer_moved <= '0;
            count_r <= '0;
          end else begin
            cur <= lstart_r;
            left <= xfer_len;
            cnt_left <= count_r;
            moved <= '0;
            to_mem_q <= xfer_to_mem;
            xfer_busy <= 1'b1;
            state <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ack) begin
          page <= entry;
          state <= S_PLAN;
        end
        S_PLAN: begin
          run_len <= run_pick;
          run_left <= run_pick;
          state <= to_mem_q ? S_GET : S_MRD;
        end
        S_GET: if (dev_in_valid) begin
          byte_q <= dev_in_data;
          state <= S_MWR;
        end
        S_MRD: if (mem_ack) begin
          byte_q <= mem_rdata[7:0];
          state <= S_PUT;
        end
        S_END: begin
          count_r <= '0;
          xfer_moved <= moved;
          xfer_busy <= 1'b0;
          xfer_done <= 1'b1;
          state <= S_IDLE;
        end
        default: ;
      endcase
      if (step) begin
        cur <= nxt;
        left <= left - LW'(1);
        cnt_left <= cnt_left - AW'(1);
        run_left <= run_left - RW'(1);
        moved <= moved + LW'(1);
        if (run_end && last_byte) state <= S_END;
        else if (run_end && page_cross) state <= S_FETCH;
        else if (run_end) state <= S_PLAN;
        else state <= to_mem_q ? S_GET : S_MRD;
      end
    end
  end
endmodule

// File: rtl/pdma_engine_sva.sv
module pdma_engine_sva #(
  parameter int AW = 32,
  parameter int RW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_word,
  input logic [AW-1:0] mem_addr,
  input logic [RW-1:0] mem_run,
  input logic          mem_ack,
  input logic          xfer_busy,
  input logic          xfer_done
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_word));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  assert_busy_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_busy) |-> xfer_done);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_busy |-> !mem_req);

  assert_run_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_word |-> $countones(mem_run) == 1);

  assert_fetch_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_word |-> !mem_we);
endmodule

bind pdma_engine pdma_engine_sva #(.AW(AW), .RW(RW)) u_sva (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_word(mem_word), .mem_addr(mem_addr), .mem_run(mem_run),
  .mem_ack(mem_ack), .xfer_busy(xfer_busy), .xfer_done(xfer_done)
);

// File: tb/pdma_engine_tb.sv
module pdma_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        xfer_start = 0, xfer_to_mem = 0;
  logic [15:0] xfer_len = 0, xfer_moved;
  logic        xfer_busy, xfer_done;
  logic        mem_req, mem_we, mem_word, mem_ack = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic [7:0]  mem_wdata;
  logic [8:0]  mem_run;
  logic        dev_in_valid = 0, dev_in_ready, dev_out_valid, dev_out_ready = 0;
  logic [7:0]  dev_in_data = 0, dev_out_data;

  pdma_engine u_dut (.*);

  int checks = 0, errors = 0;
  logic [31:0] tb_base = 0;
  logic [7:0]  din [0:8191];
  logic [7:0]  ob  [0:8191];
  logic [31:0] b_addr [0:8191];
  logic [8:0]  b_run  [0:8191];
  logic        b_we   [0:8191];
  logic [7:0]  b_wd   [0:8191];
  logic [31:0] fa [0:1023];
  int in_idx = 0, no = 0, nb = 0, nf = 0;

  function automatic logic [31:0] ent(logic [31:0] idx);
    return ((idx * 32'h9E37 + 32'h1234) << 12) | 32'h5A5;
  endfunction
  function automatic logic [7:0] mb(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    logic [31:0] e;
    e = ent((mem_addr - tb_base) >> 3);
    mem_ack <= mem_req && !mem_ack && ($urandom % 2 == 0);
    mem_rdata <= mem_word ? {e[7:0], e[15:8], e[23:16], e[31:24]} : {24'h0, mb(mem_addr)};
    if (mem_req && mem_ack) begin
      if (mem_word) begin fa[nf % 1024] <= mem_addr; nf <= nf + 1; end
      else begin
        b_addr[nb % 8192] <= mem_addr; b_run[nb % 8192] <= mem_run;
        b_we[nb % 8192] <= mem_we; b_wd[nb % 8192] <= mem_wdata; nb <= nb + 1;
      end
    end
    if (dev_in_valid && dev_in_ready) in_idx <= in_idx + 1;
    if (dev_out_valid && dev_out_ready) begin ob[no % 8192] <= dev_out_data; no <= no + 1; end
  end

  always @(negedge clk) begin
    dev_in_valid  <= ($urandom % 4 != 0);
    dev_in_data   <= din[in_idx % 8192];
    dev_out_ready <= ($urandom % 3 != 0);
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask
  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic xfer(bit to_mem, bit en_wr, bit en_run, int len, int cnt,
                      logic [31:0] la, logic [31:0] tb);
    int n, s_in, s_out, s_b, s_f, nfe, run_left, bad_a, bad_r, bad_d, bad_w;
    logic [31:0] v, pa, l, fexp [0:63];
    logic [8:0] rexp;
    bit accept;
    tb_base = tb;
    wr(3'd2, {30'h0, en_wr, en_run});
    wr(3'd3, cnt); wr(3'd4, la); wr(3'd5, tb);
    accept = en_run && (to_mem != en_wr);
    n = !accept ? 0 : (len < cnt ? len : cnt);
    @(negedge clk);
    s_in = in_idx; s_out = no; s_b = nb; s_f = nf;
    xfer_start = 1; xfer_to_mem = to_mem; xfer_len = 16'(len);
    @(negedge clk); xfer_start = 0;
    if (n > 0) chk(xfer_busy == 1, "R10 busy after start", xfer_busy, 1);
    while (!xfer_done) @(negedge clk);
    chk(xfer_moved == 16'(n), "R5/R7 bytes moved", xfer_moved, n);
    @(negedge clk);
    chk(xfer_busy == 0, "R10 busy after done", xfer_busy, 0);
    chk(nb - s_b == n, "R5/R6 data beat count", nb - s_b, n);
    nfe = 0; run_left = 0; bad_a = 0; bad_r = 0; bad_d = 0; bad_w = 0; rexp = 0;
    for (int i = 0; i < n; i++) begin
      l = la + i;
      if (i == 0 || l[11:0] == 0) begin fexp[nfe % 64] = tb + ((l >> 12) << 3); nfe++; end
      pa = {ent(l >> 12) & 32'hFFFF_F000} | {20'h0, l[11:0]};
      if (run_left == 0) begin
        if (pa[7:0] == 0 && n - i >= 256) rexp = 256;
        else if (pa[3:0] == 0 && n - i >= 16) rexp = 16;
        else rexp = 1;
        run_left = rexp;
      end
      run_left--;
      if (b_addr[(s_b+i) % 8192] != pa && bad_a == 0) begin bad_a = 1;
        chk(0, "R2 physical address", b_addr[(s_b+i) % 8192], pa); end
      if (b_run[(s_b+i) % 8192] != rexp && bad_r == 0) begin bad_r = 1;
        chk(0, "R3 run length", b_run[(s_b+i) % 8192], rexp); end
      if (b_we[(s_b+i) % 8192] != to_mem && bad_w == 0) begin bad_w = 1;
        chk(0, "R6 direction", b_we[(s_b+i) % 8192], to_mem); end
      if (to_mem) begin
        if (b_wd[(s_b+i) % 8192] != din[(s_in+i) % 8192] && bad_d == 0) begin bad_d = 1;
          chk(0, "R5 write byte order", b_wd[(s_b+i) % 8192], din[(s_in+i) % 8192]); end
      end else if (ob[(s_out+i) % 8192] != mb(pa) && bad_d == 0) begin bad_d = 1;
        chk(0, "R5 read byte order", ob[(s_out+i) % 8192], mb(pa)); end
    end
    if (n > 0) chk(bad_a + bad_r + bad_d + bad_w == 0, "R2/R3/R5 beat contents", 0, 0);
    chk(nf - s_f == nfe, "R4 table fetch count", nf - s_f, nfe);
    for (int k = 0; k < nfe && k < nf - s_f; k++)
      chk(fa[(s_f+k) % 1024] == fexp[k % 64], "R1 table fetch address", fa[(s_f+k) % 1024], fexp[k % 64]);
    rd(3'd3, v);
    if (!accept) chk(v == cnt, "R6 count kept on reject", v, cnt);
    else chk(v == 0, "R7 count cleared", v, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8192; i++) din[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk(xfer_busy == 0 && xfer_done == 0 && mem_req == 0, "R10 reset idle", xfer_busy, 0);
    rst_n = 1;
    rd(3'd3, v); chk(v == 0, "R7 count at reset", v, 0);
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); chk(v == 32'h104, "R8 config constant", v, 32'h104);
    wr(3'd1, 32'hA5A5_0001); rd(3'd1, v); chk(v == 32'hA5A5_0001, "R9 mode readback", v, 32'hA5A5_0001);
    wr(3'd6, 32'h0001_2000); rd(3'd6, v); chk(v == 32'h0001_2000, "R9 limit readback", v, 32'h0001_2000);
    wr(3'd7, 32'hDEAD_BEEF); rd(3'd7, v); chk(v == 0, "R9 invalidate ignored", v, 0);
    rd(3'd6, v); chk(v == 32'h0001_2000, "R9 limit after invalidate", v, 32'h0001_2000);
    xfer(1, 0, 1, 40, 100, 32'h0000_0FF8, 32'h0010_0000);   // R4 page crossing
    xfer(0, 1, 1, 300, 300, 32'h0000_3100, 32'h0010_0000);  // R3 long run then medium
    xfer(1, 0, 1, 255, 400, 32'h0000_5200, 32'h0020_0008);  // R3 just under long
    xfer(0, 1, 1, 200, 18, 32'h0000_7010, 32'h0010_0000);   // R5 count limits
    xfer(1, 0, 1, 15, 15, 32'h0000_2000, 32'h0010_0000);    // R3 just under medium
    xfer(1, 1, 1, 20, 20, 32'h0000_1000, 32'h0010_0000);    // R6 mismatch reject
    xfer(0, 1, 0, 20, 20, 32'h0000_1000, 32'h0010_0000);    // R6 run clear reject
    xfer(1, 0, 1, 0, 20, 32'h0000_1000, 32'h0010_0000);     // R7 zero length
    xfer(0, 1, 1, 20, 0, 32'h0000_1000, 32'h0010_0000);     // R7 zero count
    for (int r = 0; r < 10; r++) begin
      bit d;
      logic [31:0] la;
      d = 1'($urandom);
      la = $urandom % 32'h40000;
      if ($urandom % 2) la[7:0] = 0;
      xfer(d, !d, 1, 1 + $urandom % 500, 1 + $urandom % 500, la, 32'h0040_0000 + ($urandom % 16) * 8);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule